// File: doc/BRIEF.md
# Interrupt acceptance controller for an 8-bit CPU

This block decides, at each instruction boundary of an 8-bit CPU core, whether a pending non-maskable request or a maskable request is taken. It then computes the whole response: the return address to stack, the new program counter, the updated enable flip-flops and the number of T-states the response lasts. The execution unit reports each finished instruction by pulsing `bnd_valid`. With that pulse it supplies the opcode byte, whether that opcode carried the ED prefix, and the PC that follows the instruction. The controller tracks the enable pair, the interrupt mode, the vector base register, the refresh counter, the halt flag and the program counter.

The maskable response has three modes. Mode 0 only understands a restart byte from the bus. Mode 1 always calls a fixed address. Mode 2 builds a table address from the vector base register and the bus byte, and jumps through the word the system returns for that address. Acceptance is held off directly after the enable instruction, after either return-from-interrupt opcode, and after a non-maskable response. After a hardware reset the block waits a few clocks before it honours any boundary.

Top module: `irq_accept_ctrl`

## Requirements
- R1: When a non-maskable request is pending at a boundary, it wins over a maskable one. `acc_kind` becomes 1, `push_pc` becomes the boundary's `bnd_next_pc`, `pc` becomes 0x0066 and `tstates` becomes 11. The halt flag is released.
- R2: A non-maskable response clears `iff1` and leaves `iff2` at the value it held after the boundary's instruction.
- R3: A non-maskable request is never taken at the boundary that directly follows a non-maskable response. It stays pending and is taken at the boundary after that.
- R4: A maskable request is not taken at the boundary of the unprefixed opcode 0xFB (enable). It is taken at the next boundary.
- R5: A maskable request is not taken at the boundary of an ED-prefixed opcode matching 01xxx101b (either return from interrupt).
- R6: A maskable response sets `acc_kind` to 2, clears `iff1` and `iff2`, releases the halt flag and adds one to bits 6..0 of `r_reg`. Bit 7 of `r_reg` is kept.
- R7: In mode 0, a bus byte of the form 11nnn111b sends `pc` to 00nnn000b. Any other byte sends it to 0x0038. The response takes 13 T-states.
- R8: In mode 1, the bus byte is ignored, `pc` becomes 0x0038 and the response takes 13 T-states.
- R9: In mode 2, `vec_addr` is {vector base, bus byte}. `pc` becomes `vec_rd_data` and the response takes 19 T-states.
- R10: When a maskable response follows an instruction flagged by `bnd_ldair`, `pv_clear` pulses for one cycle.
- R11: Hardware reset clears `pc`, `i_reg`, `r_reg`, `iff1`, `iff2`, `halted` and `accept`, and selects mode 0.
- R12: After reset is released, `run_ok` rises on the third clock. Boundaries before that are ignored. A non-maskable edge seen during the wait stays pending.
- R13: At a boundary with no response, `pc` takes `bnd_next_pc`. The following opcodes update state:
  - unprefixed 0xFB sets both enables;
  - unprefixed 0xF3 clears both enables;
  - ED 01xxx101b copies `iff2` into `iff1`;
  - ED 0x46 selects mode 0, ED 0x56 selects mode 1 and ED 0x5E selects mode 2;
  - unprefixed 0x76 sets `halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Hardware reset, active low |
| bnd_valid | input | 1 | An instruction completes this cycle |
| bnd_opcode | input | 8 | Opcode byte of that instruction |
| bnd_ed | input | 1 | The opcode carried the ED prefix |
| bnd_ldair | input | 1 | The instruction loaded A from I or R |
| bnd_next_pc | input | 16 | PC following the instruction |
| nmi_req | input | 1 | Non-maskable request, taken on its rising edge |
| int_req | input | 1 | Maskable request level |
| resp_byte | input | 8 | Byte on the data bus in the acknowledge cycle |
| i_wr | input | 1 | Load strobe for the vector base register |
| i_wdata | input | 8 | Vector base load value |
| vec_rd_data | input | 16 | Word read at `vec_addr` |
| vec_addr | output | 16 | Mode-2 table address |
| run_ok | output | 1 | Reset wait has elapsed |
| accept | output | 1 | One-cycle response strobe |
| acc_kind | output | 2 | 0 none, 1 non-maskable, 2 maskable |
| push_pc | output | 16 | Return address to stack |
| pc | output | 16 | Program counter |
| tstates | output | 5 | Length of the response |
| iff1 | output | 1 | Enable flip-flop 1 |
| iff2 | output | 1 | Enable flip-flop 2 |
| im_mode | output | 2 | Current interrupt mode |
| i_reg | output | 8 | Vector base register |
| r_reg | output | 8 | Refresh counter |
| halted | output | 1 | Halt flag |
| pv_clear | output | 1 | Clear-parity pulse for the load quirk |

## Verification
Both request kinds can land on the same boundary. A deferring opcode (enable or return) can also coincide with a non-maskable edge. The sweep raises the non-maskable edge and the maskable level in the very cycle of each opcode class, in every mode and with the enables both set and clear. It judges the result against arithmetic on the stated rules: the non-maskable response must win, and deferral must suppress only the maskable one. Directed sequences cover a second non-maskable edge during the blocked boundary, and an edge that arrives during the reset wait.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_NMI  = 2'd1,
        ACC_INT  = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic prev;
        logic pend;
        logic block;
    } nmi_state_t;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch
    import irq_accept_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic bnd_ok,
    input  logic nmi_take,
    output logic nmi_ok
);

    nmi_state_t q, d;
    logic       pend_now;

    always_comb begin
        d        = q;
        pend_now = q.pend | (nmi_req & ~q.prev);
        nmi_ok   = pend_now & ~q.block;
        d.prev   = nmi_req;
        d.pend   = pend_now & ~nmi_take;
        if (bnd_ok) d.block = nmi_take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: a request refused at the blocked boundary stays pending
    a_r3_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_ok && q.block && pend_now) |=> q.pend);

    // R3: no take while blocked
    a_r3_block_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_ok && q.block) |-> !nmi_take);

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8,
    parameter int TS_W   = 5,
    parameter int FIX_VEC = 16'h0038,
    parameter int T_IM01 = 13,
    parameter int T_IM2  = 19
) (
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] resp_byte,
    input  logic [PC_W-1:0]   table_word,
    output logic [PC_W-1:0]   target,
    output logic [TS_W-1:0]   tcount
);

    localparam logic [PC_W-1:0] FIX_TARGET = PC_W'(FIX_VEC);
    logic is_restart;

    always_comb begin
        is_restart = (resp_byte[7:6] == 2'b11) && (resp_byte[2:0] == 3'b111);
        target     = FIX_TARGET;
        tcount     = TS_W'(T_IM01);
        case (mode)
            2'd0: if (is_restart) target = PC_W'({resp_byte[5:3], 3'b000});
            2'd2: begin
                target = table_word;
                tcount = TS_W'(T_IM2);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_accept_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int DATA_W   = 8,
    parameter int TS_W     = 5,
    parameter int RST_WAIT = 3,
    parameter int NMI_VEC  = 16'h0066,
    parameter int T_NMI    = 11,
    parameter bit NMOS_PV_QUIRK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bnd_valid,
    input  logic [7:0]        bnd_opcode,
    input  logic              bnd_ed,
    input  logic              bnd_ldair,
    input  logic [PC_W-1:0]   bnd_next_pc,
    input  logic              nmi_req,
    input  logic              int_req,
    input  logic [DATA_W-1:0] resp_byte,
    input  logic              i_wr,
    input  logic [DATA_W-1:0] i_wdata,
    input  logic [PC_W-1:0]   vec_rd_data,
    output logic [PC_W-1:0]   vec_addr,
    output logic              run_ok,
    output logic              accept,
    output logic [1:0]        acc_kind,
    output logic [PC_W-1:0]   push_pc,
    output logic [PC_W-1:0]   pc,
    output logic [TS_W-1:0]   tstates,
    output logic              iff1,
    output logic              iff2,
    output logic [1:0]        im_mode,
    output logic [DATA_W-1:0] i_reg,
    output logic [7:0]        r_reg,
    output logic              halted,
    output logic              pv_clear
);

    localparam int WAIT_W = $clog2(RST_WAIT + 1);
    localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(RST_WAIT);

    typedef struct packed {
        logic [WAIT_W-1:0] wait_cnt;
        logic              iff1;
        logic              iff2;
        logic [1:0]        im;
        logic [DATA_W-1:0] i;
        logic [7:0]        r;
        logic              halted;
        logic [PC_W-1:0]   pc;
        logic              accept;
        acc_kind_e         kind;
        logic [PC_W-1:0]   push;
        logic [TS_W-1:0]   tst;
        logic              pv_clr;
    } ctrl_state_t;

    ctrl_state_t q, d;

    logic            bnd_ok, nmi_ok, nmi_take, int_take, quirk_hit;
    logic            is_ei, is_di, is_retx, is_im, is_halt;
    logic            iff1_a, iff2_a, halt_a;
    logic [1:0]      im_a;
    logic [PC_W-1:0] int_target;
    logic [TS_W-1:0] int_tst;

    assign run_ok   = (q.wait_cnt == WAIT_END);
    assign bnd_ok   = bnd_valid && run_ok;
    assign vec_addr = {q.i, resp_byte};

    assign is_ei   = !bnd_ed && (bnd_opcode == 8'hFB);
    assign is_di   = !bnd_ed && (bnd_opcode == 8'hF3);
    assign is_halt = !bnd_ed && (bnd_opcode == 8'h76);
    assign is_retx = bnd_ed && (bnd_opcode[7:6] == 2'b01) && (bnd_opcode[2:0] == 3'b101);
    assign is_im   = bnd_ed && (bnd_opcode[7:6] == 2'b01) && (bnd_opcode[2:0] == 3'b110);

    generate
        if (NMOS_PV_QUIRK) begin : g_quirk
            assign quirk_hit = bnd_ldair;
        end else begin : g_no_quirk
            assign quirk_hit = 1'b0;
        end
    endgenerate

    irq_nmi_latch u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .bnd_ok   (bnd_ok),
        .nmi_take (nmi_take),
        .nmi_ok   (nmi_ok)
    );

    irq_vector_gen #(
        .PC_W   (PC_W),
        .DATA_W (DATA_W),
        .TS_W   (TS_W)
    ) u_vec (
        .mode       (im_a),
        .resp_byte  (resp_byte),
        .table_word (vec_rd_data),
        .target     (int_target),
        .tcount     (int_tst)
    );

    always_comb begin
        d        = q;
        d.accept = 1'b0;
        d.kind   = ACC_NONE;
        d.pv_clr = 1'b0;
        if (q.wait_cnt != WAIT_END) d.wait_cnt = q.wait_cnt + 1'b1;
        if (i_wr) d.i = i_wdata;

        iff1_a = q.iff1;
        iff2_a = q.iff2;
        im_a   = q.im;
        halt_a = q.halted;
        if (is_ei) begin
            iff1_a = 1'b1;
            iff2_a = 1'b1;
        end
        if (is_di) begin
            iff1_a = 1'b0;
            iff2_a = 1'b0;
        end
        if (is_retx) iff1_a = q.iff2;
        if (is_im)   im_a = bnd_opcode[4] ? (bnd_opcode[3] ? 2'd2 : 2'd1) : 2'd0;
        if (is_halt) halt_a = 1'b1;

        nmi_take = bnd_ok && nmi_ok;
        int_take = bnd_ok && !nmi_ok && int_req && iff1_a && !is_ei && !is_retx;

        if (bnd_ok) begin
            d.iff1   = iff1_a;
            d.iff2   = iff2_a;
            d.im     = im_a;
            d.halted = halt_a;
            d.pc     = bnd_next_pc;
            if (nmi_take || int_take) begin
                d.accept = 1'b1;
                d.push   = bnd_next_pc;
                d.halted = 1'b0;
                d.r      = {q.r[7], q.r[6:0] + 7'd1};
                d.iff1   = 1'b0;
            end
            if (nmi_take) begin
                d.kind = ACC_NMI;
                d.pc   = PC_W'(NMI_VEC);
                d.tst  = TS_W'(T_NMI);
            end else if (int_take) begin
                d.kind   = ACC_INT;
                d.pc     = int_target;
                d.tst    = int_tst;
                d.iff2   = 1'b0;
                d.pv_clr = quirk_hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.kind <= ACC_NONE;
        end else begin
            q <= d;
        end
    end

    assign accept   = q.accept;
    assign acc_kind = q.kind;
    assign push_pc  = q.push;
    assign pc       = q.pc;
    assign tstates  = q.tst;
    assign iff1     = q.iff1;
    assign iff2     = q.iff2;
    assign im_mode  = q.im;
    assign i_reg    = q.i;
    assign r_reg    = q.r;
    assign halted   = q.halted;
    assign pv_clear = q.pv_clr;

    a_r1_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_kind == ACC_NMI) |-> (pc == PC_W'(NMI_VEC) && tstates == TS_W'(T_NMI)));

    a_r2_nmi_iff1_low: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_kind == ACC_NMI) |-> !iff1);

    a_r3_no_nmi_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_kind == ACC_NMI) |=> !(accept && acc_kind == ACC_NMI));

    a_r4_ei_defers: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_ok && is_ei) |=> !(accept && acc_kind == ACC_INT));

    a_r5_ret_defers: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_ok && is_retx) |=> !(accept && acc_kind == ACC_INT));

    a_r6_int_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_kind == ACC_INT) |-> (!iff1 && !iff2 && !halted));

    a_r10_pv_only_int: assert property (@(posedge clk) disable iff (!rst_n)
        pv_clear |-> (accept && acc_kind == ACC_INT));

    a_r12_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |-> !accept);

    a_r1_kind_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        accept == (acc_kind != ACC_NONE));

endmodule

// File: tb/irq_accept_ctrl_test.sv
module irq_accept_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bnd_valid = 1'b0;
    logic [7:0]  bnd_opcode = 8'h00;
    logic        bnd_ed = 1'b0;
    logic        bnd_ldair = 1'b0;
    logic [15:0] bnd_next_pc = 16'h0000;
    logic        nmi_req = 1'b0;
    logic        int_req = 1'b0;
    logic [7:0]  resp_byte = 8'h00;
    logic        i_wr = 1'b0;
    logic [7:0]  i_wdata = 8'h00;
    logic [15:0] vec_rd_data;
    logic [15:0] vec_addr, push_pc, pc;
    logic        run_ok, accept, iff1, iff2, halted, pv_clear;
    logic [1:0]  acc_kind, im_mode;
    logic [4:0]  tstates;
    logic [7:0]  i_reg, r_reg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    // mode-2 table model: word at address A is byte-swapped A xor 0F0F
    assign vec_rd_data = {vec_addr[7:0], vec_addr[15:8]} ^ 16'h0F0F;

    irq_accept_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_opcode(bnd_opcode),
        .bnd_ed(bnd_ed), .bnd_ldair(bnd_ldair), .bnd_next_pc(bnd_next_pc),
        .nmi_req(nmi_req), .int_req(int_req), .resp_byte(resp_byte),
        .i_wr(i_wr), .i_wdata(i_wdata), .vec_rd_data(vec_rd_data),
        .vec_addr(vec_addr), .run_ok(run_ok), .accept(accept), .acc_kind(acc_kind),
        .push_pc(push_pc), .pc(pc), .tstates(tstates), .iff1(iff1), .iff2(iff2),
        .im_mode(im_mode), .i_reg(i_reg), .r_reg(r_reg), .halted(halted),
        .pv_clear(pv_clear)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bnd_valid = 1'b0; nmi_req = 1'b0; int_req = 1'b0;
        i_wr = 1'b0; bnd_ldair = 1'b0; bnd_ed = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bnd(input logic [7:0] op, input logic ed, input logic ldair,
                       input logic [15:0] npc);
        bnd_valid = 1'b1; bnd_opcode = op; bnd_ed = ed; bnd_ldair = ldair;
        bnd_next_pc = npc;
        @(posedge clk);
        @(negedge clk);
        bnd_valid = 1'b0; bnd_ldair = 1'b0; bnd_ed = 1'b0;
    endtask

    task automatic load_i(input logic [7:0] v);
        i_wr = 1'b1; i_wdata = v;
        @(negedge clk);
        i_wr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb_tab [3];
        rb_tab[0] = 8'hD7; rb_tab[1] = 8'hFF; rb_tab[2] = 8'h3E;

        // R11 reset values, R12 wait window
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 pc", pc, 0); check("R11 iff1", iff1, 0); check("R11 iff2", iff2, 0);
        check("R11 im", im_mode, 0); check("R11 i", i_reg, 0); check("R11 r", r_reg, 0);
        check("R11 accept", accept, 0); check("R11 halted", halted, 0);
        rst_n = 1'b1;
        nmi_req = 1'b1;
        bnd(8'h00, 1'b0, 1'b0, 16'h1234);
        check("R12 ignored accept", accept, 0);
        check("R12 ignored pc", pc, 0);
        check("R12 run_ok low", run_ok, 0);
        @(negedge clk);
        check("R12 run_ok low2", run_ok, 0);
        @(negedge clk);
        check("R12 run_ok high", run_ok, 1);
        bnd(8'h00, 1'b0, 1'b0, 16'h0100);
        check("R12 pending taken", acc_kind, 1);
        check("R1 push", push_pc, 16'h0100);
        check("R1 pc", pc, 16'h0066);

        // R3: a second edge at the blocked boundary
        nmi_req = 1'b0;
        @(negedge clk);
        nmi_req = 1'b1;
        bnd(8'h00, 1'b0, 1'b0, 16'h0067);
        check("R3 blocked accept", accept, 0);
        check("R3 blocked pc", pc, 16'h0067);
        bnd(8'h00, 1'b0, 1'b0, 16'h0068);
        check("R3 later accept", acc_kind, 1);
        nmi_req = 1'b0;

        // R4: enable then next instruction
        do_reset();
        int_req = 1'b1; resp_byte = 8'hFF;
        bnd(8'hFB, 1'b0, 1'b0, 16'h0201);
        check("R4 deferred", accept, 0);
        check("R13 ei sets iff1", iff1, 1);
        bnd(8'h00, 1'b0, 1'b0, 16'h0202);
        check("R4 taken after", acc_kind, 2);
        check("R6 iff1", iff1, 0);
        check("R6 iff2", iff2, 0);
        check("R7 ff byte", pc, 16'h0038);
        int_req = 1'b0;

        // R6 halt release and refresh count
        do_reset();
        bnd(8'hFB, 1'b0, 1'b0, 16'h0001);
        bnd(8'h00, 1'b0, 1'b0, 16'h0002);
        bnd(8'h76, 1'b0, 1'b0, 16'h0003);
        check("R13 halt set", halted, 1);
        int_req = 1'b1;
        bnd(8'h00, 1'b0, 1'b0, 16'h0003);
        check("R6 halt released", halted, 0);
        check("R6 r incr", r_reg, 1);
        check("R6 push", push_pc, 16'h0003);
        int_req = 1'b0;

        // sweep: mode x opcode class x enables x request mix x bus byte
        for (int md = 0; md < 3; md++)
        for (int cl = 0; cl < 6; cl++)
        for (int en = 0; en < 2; en++)
        for (int st = 0; st < 4; st++)
        for (int rb = 0; rb < 3; rb++) begin
            logic [7:0]  op, ival, rsp;
            logic        ed, lda, blk, e1, e2, want_nmi, want_int;
            logic [15:0] npc, tgt;
            logic [4:0]  tt;
            do_reset();
            bnd(md == 0 ? 8'h46 : (md == 1 ? 8'h56 : 8'h5E), 1'b1, 1'b0, 16'h0010);
            check("R13 im select", im_mode, md);
            if (en != 0) begin
                bnd(8'hFB, 1'b0, 1'b0, 16'h0011);
                bnd(8'h00, 1'b0, 1'b0, 16'h0012);
            end
            ival = 8'(md * 64 + cl * 8 + en * 4 + rb);
            load_i(ival);
            rsp = rb_tab[rb];
            case (cl)
                0: begin op = 8'h00; ed = 0; end
                1: begin op = 8'hFB; ed = 0; end
                2: begin op = 8'hF3; ed = 0; end
                3: begin op = 8'h45; ed = 1; end
                4: begin op = 8'h4D; ed = 1; end
                default: begin op = 8'h57; ed = 1; end
            endcase
            lda = (cl == 5);
            blk = (cl == 1) || (cl == 3) || (cl == 4);
            e1 = (en != 0); e2 = (en != 0);
            if (cl == 1) begin e1 = 1; e2 = 1; end
            if (cl == 2) begin e1 = 0; e2 = 0; end
            want_nmi = st[1];
            want_int = !want_nmi && st[0] && e1 && !blk;
            npc = 16'h4000 + 16'(md * 256 + cl * 16 + st * 4 + rb);
            if (md == 0) tgt = (rsp[7:6] == 2'b11 && rsp[2:0] == 3'b111) ? {10'd0, rsp[5:3], 3'd0} : 16'h0038;
            else if (md == 1) tgt = 16'h0038;
            else tgt = {rsp, ival} ^ 16'h0F0F;
            tt = (md == 2) ? 5'd19 : 5'd13;
            int_req = st[0]; nmi_req = st[1]; resp_byte = rsp;
            bnd(op, ed, lda, npc);
            if (want_nmi) begin
                check("R1 kind", acc_kind, 1);
                check("R1 push", push_pc, npc);
                check("R1 pc", pc, 16'h0066);
                check("R1 tstates", tstates, 11);
                check("R2 iff1", iff1, 0);
                check("R2 iff2", iff2, e2);
                check("R6 r nmi", r_reg, 1);
            end else if (want_int) begin
                check("R6 kind", acc_kind, 2);
                check("R6 push", push_pc, npc);
                check(md == 0 ? "R7 pc" : (md == 1 ? "R8 pc" : "R9 pc"), pc, tgt);
                check(md == 2 ? "R9 tstates" : "R7 R8 tstates", tstates, tt);
                check("R6 iffs", {iff1, iff2}, 0);
                check("R6 r", r_reg, 1);
                check("R10 pv", pv_clear, lda);
            end else begin
                check(blk ? "R4 R5 none" : "R13 none", accept, 0);
                check("R13 pc", pc, npc);
                check("R13 iff1", iff1, e1);
                check("R13 iff2", iff2, e2);
                check("R10 pv idle", pv_clear, 0);
            end
            if (md == 2) check("R9 vec_addr", vec_addr, {ival, rsp});
            int_req = 1'b0; nmi_req = 1'b0;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule